// File: doc/BRIEF.md
# Adapter Option Registers and Memory Window Decoder

This block holds the small set of I/O-mapped option registers of a network adapter, together with the decoder for the 16 KB host memory window that those registers place and switch on. Eight consecutive I/O offsets are decoded. Two of them return a fixed card identity. Three of them can be written: an option byte, a window base byte and an interrupt choice. The rest read as zero. Reads are combinational on the I/O offset. Writes land on the rising clock edge when the write strobe is high.

When the card-enable option is set and host address bits 19..14 match the programmed base, the decoder classifies the low 14 address bits. The result selects one of these targets: shared RAM, the station-address PROM, a reserved gap, the controller data register, the status/control byte or the command byte. The block drives only select strobes, the in-window offset, the PROM byte index and a byte-wide window read value. The RAM, the PROM contents and the bus-master controller are outside the block.

Top module: `osw_top`

## Requirements
- R1: I/O offset 0 reads 0xFD and offset 1 reads 0x6A at all times; writes to either offset change nothing.
- R2: I/O offsets 5, 6 and 7 read 0x00; writes to them change no readback and no output.
- R3: Offset 2 keeps written bits [1:0] and reads bits [7:2] as zero. Bit 0 drives `cardEnable`. Bit 1 set turns the boot ROM off, so `bootRomEnable` is the inverse of bit 1.
- R4: Offset 3 keeps written bits [5:0] as the window base (host A19..A14) and reads bits [7:6] as zero.
- R5: Offset 4 keeps a full 8-bit interrupt selection, driven on `irqSelect`.
- R6: After reset, offsets 2, 3 and 4 read zero, `cardEnable` is 0, `bootRomEnable` is 1 and `irqSelect` is 0.
- R7: A window hit needs `cardEnable` high and `memAddr[19:14]` equal to the base. Without a hit, every select is low and `winRdByte` is 0x00.
- R8: A hit at window offsets 0x0000..0x3FBF raises `ramSel`. `winOffset` always equals `memAddr[13:0]`.
- R9: A hit at 0x3FC0..0x3FDF raises `promSel`, and `promIdx` equals `memAddr[4:1]`. On an even offset, `winRdByte` equals `promByte`.
- R10: A PROM hit on an odd offset drives `winRdByte` to 0xFF.
- R11: A hit at 0x3FE0..0x3FEF or 0x3FF4..0x3FFF raises `rsvdSel` with `winRdByte` 0xFF. Every hit other than a PROM or reserved one drives `winRdByte` 0x00.
- R12: A hit at 0x3FF0 or 0x3FF1 raises `dataRegSel`, at 0x3FF2 it raises `statCtrlSel`, and at 0x3FF3 it raises `cmdSel`. At most one select is high in any cycle.
- R13: A write is seen on readback and on the outputs only after the clock edge that samples it. In the cycle the strobe is high, the old value still shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 3 | Option register offset |
| ioWrEn | input | 1 | Write strobe for the option registers |
| ioWrData | input | 8 | Write data |
| ioRdData | output | 8 | Combinational readback of the addressed offset |
| memAddr | input | 20 | Host memory address |
| promByte | input | 8 | Byte returned by the external PROM at `promIdx` |
| cardEnable | output | 1 | Card enable option |
| bootRomEnable | output | 1 | High while the boot ROM is on |
| irqSelect | output | 8 | Interrupt selection |
| ramSel | output | 1 | Shared RAM select |
| promSel | output | 1 | Address PROM select |
| rsvdSel | output | 1 | Reserved region select |
| dataRegSel | output | 1 | Controller data register select |
| statCtrlSel | output | 1 | Status/control byte select |
| cmdSel | output | 1 | Command byte select |
| winOffset | output | 14 | Offset inside the window |
| promIdx | output | 4 | PROM byte index |
| winRdByte | output | 8 | Window read value for PROM and reserved hits |

## Verification
Readback, selects, offsets and the window byte are pure functions of the current inputs and the three option registers, so they are due in the same cycle as the address. A write is due one edge later. The bench drives every input just after a falling edge and compares shortly after that, before the next rising edge. Its behavioural model updates its register copies only after that rising edge. Because of this, a write cycle is compared against the old values and the next cycle against the new ones.

// File: rtl/osw_pkg.sv
package osw_pkg;

  // offsets fixed by the I/O map
  typedef enum logic [2:0] {
    SLOT_ID_LO = 3'd0,
    SLOT_ID_HI = 3'd1,
    SLOT_OPT   = 3'd2,
    SLOT_BASE  = 3'd3,
    SLOT_IRQ   = 3'd4
  } oswSlot_e;

  typedef enum logic [2:0] {
    RGN_NONE,
    RGN_RAM,
    RGN_PROM,
    RGN_RSVD,
    RGN_DATA,
    RGN_STAT,
    RGN_CMD
  } oswRegion_e;

  typedef struct packed {
    logic       wrOpt;
    logic       wrBase;
    logic       wrIrq;
    oswRegion_e region;
  } oswStrobe_t;

endpackage

// File: rtl/osw_ctrl.sv
module osw_ctrl
  import osw_pkg::*;
#(
  parameter int IO_W   = 3,
  parameter int ADDR_W = 20,
  parameter int WIN_W  = 14
) (
  input  logic [IO_W-1:0]         ioAddr,
  input  logic                    ioWrEn,
  input  logic [ADDR_W-1:0]       memAddr,
  input  logic                    cardEn,
  input  logic [ADDR_W-WIN_W-1:0] baseBits,
  output oswStrobe_t              strobe
);

  localparam int WIN_BYTES = 1 << WIN_W;
  localparam logic [WIN_W-1:0] PROM_LO = WIN_W'(WIN_BYTES - 64);
  localparam logic [WIN_W-1:0] RSVD_LO = WIN_W'(WIN_BYTES - 32);
  localparam logic [WIN_W-1:0] REGS_LO = WIN_W'(WIN_BYTES - 16);

  logic [WIN_W-1:0] offset;
  logic             hit;

  assign offset = memAddr[WIN_W-1:0];
  assign hit    = cardEn && (memAddr[ADDR_W-1:WIN_W] == baseBits);

  always_comb begin
    strobe.wrOpt  = ioWrEn && (ioAddr == IO_W'(SLOT_OPT));
    strobe.wrBase = ioWrEn && (ioAddr == IO_W'(SLOT_BASE));
    strobe.wrIrq  = ioWrEn && (ioAddr == IO_W'(SLOT_IRQ));
    if (!hit)                   strobe.region = RGN_NONE;
    else if (offset < PROM_LO)  strobe.region = RGN_RAM;
    else if (offset < RSVD_LO)  strobe.region = RGN_PROM;
    else if (offset < REGS_LO)  strobe.region = RGN_RSVD;
    else begin
      case (offset[3:0])
        4'h0, 4'h1: strobe.region = RGN_DATA;
        4'h2:       strobe.region = RGN_STAT;
        4'h3:       strobe.region = RGN_CMD;
        default:    strobe.region = RGN_RSVD;
      endcase
    end
  end

endmodule

// File: rtl/osw_datapath.sv
module osw_datapath
  import osw_pkg::*;
#(
  parameter int IO_W   = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 20,
  parameter int WIN_W  = 14,
  parameter logic [DATA_W-1:0] ID_LO = 8'hFD,
  parameter logic [DATA_W-1:0] ID_HI = 8'h6A
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  oswStrobe_t              strobe,
  input  logic [IO_W-1:0]         ioAddr,
  input  logic [DATA_W-1:0]       ioWrData,
  input  logic [ADDR_W-1:0]       memAddr,
  input  logic [DATA_W-1:0]       promByte,
  output logic [DATA_W-1:0]       ioRdData,
  output logic                    cardEn,
  output logic [ADDR_W-WIN_W-1:0] baseBits,
  output logic                    bootRomEnable,
  output logic [DATA_W-1:0]       irqSelect,
  output logic                    ramSel,
  output logic                    promSel,
  output logic                    rsvdSel,
  output logic                    dataRegSel,
  output logic                    statCtrlSel,
  output logic                    cmdSel,
  output logic [WIN_W-1:0]        winOffset,
  output logic [3:0]              promIdx,
  output logic [DATA_W-1:0]       winRdByte
);

  localparam int OPT_W  = 2;
  localparam int BASE_W = ADDR_W - WIN_W;

  logic [OPT_W-1:0]  optReg;
  logic [BASE_W-1:0] baseReg;
  logic [DATA_W-1:0] irqReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      optReg  <= '0;
      baseReg <= '0;
      irqReg  <= '0;
    end else begin
      if (strobe.wrOpt)  optReg  <= ioWrData[OPT_W-1:0];
      if (strobe.wrBase) baseReg <= ioWrData[BASE_W-1:0];
      if (strobe.wrIrq)  irqReg  <= ioWrData;
    end
  end

  always_comb begin
    case (ioAddr)
      IO_W'(SLOT_ID_LO): ioRdData = ID_LO;
      IO_W'(SLOT_ID_HI): ioRdData = ID_HI;
      IO_W'(SLOT_OPT):   ioRdData = DATA_W'(optReg);
      IO_W'(SLOT_BASE):  ioRdData = DATA_W'(baseReg);
      IO_W'(SLOT_IRQ):   ioRdData = irqReg;
      default:           ioRdData = '0;
    endcase
  end

  assign cardEn        = optReg[0];
  assign bootRomEnable = !optReg[1];
  assign baseBits      = baseReg;
  assign irqSelect     = irqReg;

  assign ramSel      = (strobe.region == RGN_RAM);
  assign promSel     = (strobe.region == RGN_PROM);
  assign rsvdSel     = (strobe.region == RGN_RSVD);
  assign dataRegSel  = (strobe.region == RGN_DATA);
  assign statCtrlSel = (strobe.region == RGN_STAT);
  assign cmdSel      = (strobe.region == RGN_CMD);

  assign winOffset = memAddr[WIN_W-1:0];
  assign promIdx   = memAddr[4:1];

  always_comb begin
    if (promSel && !memAddr[0])  winRdByte = promByte;
    else if (promSel || rsvdSel) winRdByte = '1;
    else                         winRdByte = '0;
  end

endmodule

// File: rtl/osw_top.sv
module osw_top
  import osw_pkg::*;
#(
  parameter int IO_W   = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 20,
  parameter int WIN_W  = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IO_W-1:0]   ioAddr,
  input  logic              ioWrEn,
  input  logic [DATA_W-1:0] ioWrData,
  output logic [DATA_W-1:0] ioRdData,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] promByte,
  output logic              cardEnable,
  output logic              bootRomEnable,
  output logic [DATA_W-1:0] irqSelect,
  output logic              ramSel,
  output logic              promSel,
  output logic              rsvdSel,
  output logic              dataRegSel,
  output logic              statCtrlSel,
  output logic              cmdSel,
  output logic [WIN_W-1:0]  winOffset,
  output logic [3:0]        promIdx,
  output logic [DATA_W-1:0] winRdByte
);

  oswStrobe_t              strobe;
  logic [ADDR_W-WIN_W-1:0] baseBits;

  osw_ctrl #(.IO_W(IO_W), .ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_ctrl (
    .ioAddr   (ioAddr),
    .ioWrEn   (ioWrEn),
    .memAddr  (memAddr),
    .cardEn   (cardEnable),
    .baseBits (baseBits),
    .strobe   (strobe)
  );

  osw_datapath #(.IO_W(IO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .ioAddr        (ioAddr),
    .ioWrData      (ioWrData),
    .memAddr       (memAddr),
    .promByte      (promByte),
    .ioRdData      (ioRdData),
    .cardEn        (cardEnable),
    .baseBits      (baseBits),
    .bootRomEnable (bootRomEnable),
    .irqSelect     (irqSelect),
    .ramSel        (ramSel),
    .promSel       (promSel),
    .rsvdSel       (rsvdSel),
    .dataRegSel    (dataRegSel),
    .statCtrlSel   (statCtrlSel),
    .cmdSel        (cmdSel),
    .winOffset     (winOffset),
    .promIdx       (promIdx),
    .winRdByte     (winRdByte)
  );

endmodule

// File: rtl/osw_checker.sv
module osw_checker #(
  parameter int IO_W   = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic [IO_W-1:0]   ioAddr,
  input logic              ioWrEn,
  input logic [DATA_W-1:0] ioWrData,
  input logic [DATA_W-1:0] ioRdData,
  input logic [ADDR_W-1:0] memAddr,
  input logic              cardEnable,
  input logic [DATA_W-1:0] irqSelect,
  input logic              ramSel,
  input logic              promSel,
  input logic              rsvdSel,
  input logic              dataRegSel,
  input logic              statCtrlSel,
  input logic              cmdSel,
  input logic [DATA_W-1:0] winRdByte
);

  assert_id_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ioAddr == IO_W'(0)) |-> (ioRdData == 8'hFD));

  assert_one_select_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ramSel, promSel, rsvdSel, dataRegSel, statCtrlSel, cmdSel}));

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !cardEnable |-> !(ramSel || promSel || rsvdSel || dataRegSel || statCtrlSel || cmdSel));

  assert_odd_prom_R10: assert property (@(posedge clk) disable iff (!rstN)
    (promSel && memAddr[0]) |-> (winRdByte == 8'hFF));

  assert_irq_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && ioAddr == IO_W'(4)) |=> (irqSelect == $past(ioWrData)));

  assert_enable_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(ioWrEn && ioAddr == IO_W'(2)) |=> $stable(cardEnable));

endmodule

bind osw_top osw_checker #(.IO_W(IO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .ioAddr      (ioAddr),
  .ioWrEn      (ioWrEn),
  .ioWrData    (ioWrData),
  .ioRdData    (ioRdData),
  .memAddr     (memAddr),
  .cardEnable  (cardEnable),
  .irqSelect   (irqSelect),
  .ramSel      (ramSel),
  .promSel     (promSel),
  .rsvdSel     (rsvdSel),
  .dataRegSel  (dataRegSel),
  .statCtrlSel (statCtrlSel),
  .cmdSel      (cmdSel),
  .winRdByte   (winRdByte)
);

// File: tb/osw_top_tb.sv
module osw_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  ioAddr = '0;
  logic        ioWrEn = 1'b0;
  logic [7:0]  ioWrData = '0;
  logic [7:0]  ioRdData;
  logic [19:0] memAddr = '0;
  logic [7:0]  promByte = '0;
  logic        cardEnable, bootRomEnable;
  logic [7:0]  irqSelect;
  logic        ramSel, promSel, rsvdSel, dataRegSel, statCtrlSel, cmdSel;
  logic [13:0] winOffset;
  logic [3:0]  promIdx;
  logic [7:0]  winRdByte;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // behavioural model state
  int mOpt = 0;
  int mBase = 0;
  int mIrq = 0;

  always #10 clk = ~clk;

  osw_top u_dut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioWrData(ioWrData),
    .ioRdData(ioRdData), .memAddr(memAddr), .promByte(promByte),
    .cardEnable(cardEnable), .bootRomEnable(bootRomEnable), .irqSelect(irqSelect),
    .ramSel(ramSel), .promSel(promSel), .rsvdSel(rsvdSel), .dataRegSel(dataRegSel),
    .statCtrlSel(statCtrlSel), .cmdSel(cmdSel), .winOffset(winOffset),
    .promIdx(promIdx), .winRdByte(winRdByte)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    int off, rd, sel, wb;
    string rq, wrq;
    bit hit;
    case (int'(ioAddr))
      0: rd = 'hFD;
      1: rd = 'h6A;
      2: rd = mOpt;
      3: rd = mBase;
      4: rd = mIrq;
      default: rd = 0;
    endcase
    case (int'(ioAddr))
      0, 1: rq = "R1";
      2: rq = "R3";
      3: rq = "R4";
      4: rq = "R5";
      default: rq = "R2";
    endcase
    if (ioWrEn && ioAddr inside {3'd2, 3'd3, 3'd4}) rq = "R13";
    check(rq, "ioRdData", int'(ioRdData), rd);
    check("R3", "cardEnable", int'(cardEnable), mOpt % 2);
    check("R3", "bootRomEnable", int'(bootRomEnable), (mOpt / 2) % 2 ? 0 : 1);
    check("R5", "irqSelect", int'(irqSelect), mIrq);
    off = int'(memAddr) % 16384;
    hit = (mOpt % 2 == 1) && (int'(memAddr) / 16384 == mBase);
    // select vector {ram,prom,rsvd,data,stat,cmd} as bits 5..0
    sel = 0; wb = 0;
    if (!hit) wrq = "R7";
    else if (off < 'h3FC0) begin sel = 32; wrq = "R8"; end
    else if (off < 'h3FE0) begin
      sel = 16;
      if (off % 2 == 0) begin wb = int'(promByte); wrq = "R9"; end
      else begin wb = 'hFF; wrq = "R10"; end
    end
    else if (off < 'h3FF0 || off > 'h3FF3) begin sel = 8; wb = 'hFF; wrq = "R11"; end
    else if (off <= 'h3FF1) begin sel = 4; wrq = "R12"; end
    else if (off == 'h3FF2) begin sel = 2; wrq = "R12"; end
    else begin sel = 1; wrq = "R12"; end
    check(wrq, "selects", int'({ramSel, promSel, rsvdSel, dataRegSel, statCtrlSel, cmdSel}), sel);
    check(wrq, "winRdByte", int'(winRdByte), wb);
    check("R8", "winOffset", int'(winOffset), off);
    check("R9", "promIdx", int'(promIdx), (off / 2) % 16);
  endtask

  task automatic step(input int a, input bit we, input int d, input int mem, input int pb);
    @(negedge clk);
    ioAddr = a[2:0]; ioWrEn = we; ioWrData = d[7:0]; memAddr = mem[19:0]; promByte = pb[7:0];
    #2;
    compareAll();
    @(posedge clk);
    if (rstN && we) begin
      case (a)
        2: mOpt = d % 4;
        3: mBase = d % 64;
        4: mIrq = d % 256;
        default: ;
      endcase
    end
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int win;
    int offs[14];
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // R6: reset state
    @(negedge clk); ioAddr = 3'd2; #2;
    check("R6", "opt after reset", int'(ioRdData), 0);
    ioAddr = 3'd3; #2;
    check("R6", "base after reset", int'(ioRdData), 0);
    ioAddr = 3'd4; #2;
    check("R6", "irq after reset", int'(ioRdData), 0);
    check("R6", "cardEnable", int'(cardEnable), 0);
    check("R6", "bootRomEnable", int'(bootRomEnable), 1);
    // R1, R2: every offset, then writes to fixed/unused offsets
    for (int i = 0; i < 8; i++) step(i, 0, 0, 0, 0);
    step(0, 1, 'h11, 0, 0);
    step(1, 1, 'h22, 0, 0);
    step(5, 1, 'h33, 0, 0);
    step(7, 1, 'hFF, 0, 0);
    for (int i = 0; i < 8; i++) step(i, 0, 0, 0, 0);
    // R3, R4, R5, R13: program card at base 0x33
    step(3, 1, 'hF3, 0, 0);
    step(3, 0, 0, 0, 0);
    step(4, 1, 'h0B, 0, 0);
    step(2, 1, 'hFD, 0, 0);
    step(2, 0, 0, 0, 0);
    // R8..R12 region boundaries
    win = 'h33 * 16384;
    offs = '{'h0000, 'h3FBF, 'h3FC0, 'h3FC1, 'h3FDE, 'h3FDF, 'h3FE0,
             'h3FEF, 'h3FF0, 'h3FF1, 'h3FF2, 'h3FF3, 'h3FF4, 'h3FFF};
    for (int i = 0; i < 14; i++) step(2, 0, 0, win + offs[i], 'hA5 + i);
    // R7: other base, then card disabled
    step(2, 0, 0, 'h32 * 16384 + 'h3FC0, 'h5A);
    step(2, 1, 'h02, 0, 0);
    step(2, 0, 0, win + 'h3FC0, 'h5A);
    step(2, 0, 0, win + 'h10, 0);
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int a, d, m;
      bit we;
      a = $urandom_range(0, 7);
      we = ($urandom_range(0, 5) == 0);
      d = $urandom_range(0, 255);
      if (a == 2 && $urandom_range(0, 3) != 0) d = d | 1;
      if ($urandom_range(0, 3) == 0) m = $urandom_range(0, 'hFFFFF);
      else if ($urandom_range(0, 1) == 0) m = mBase * 16384 + $urandom_range('h3FB0, 'h3FFF);
      else m = mBase * 16384 + $urandom_range(0, 'h3FFF);
      step(a, we, d, m, $urandom_range(0, 255));
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule